// File: doc/BRIEF.md
# CPU/Video Bus Time-Share Controller

This block divides a memory bus between a CPU and a display fetch engine built from plain logic. A free-running counter splits time into two equal halves per frame. In the first half the CPU owns the bus. In the second half the block asks for the bus through a request line. When the CPU grants the bus with an acknowledge, the block opens a fetch window in which the display may read video memory. At the end of the half the request drops and the CPU resumes. The CPU therefore never runs during the visible picture, so the two never contend for memory. With a 2 MHz CPU clock and about 20492 clocks per half, the frame rate is close to 48.8 Hz and the CPU averages about 1 MHz.

A screen-enable bit is held in a general output port register, written through the CPU's I/O write path. While that bit is 0, the block raises no requests and keeps the display blanked, so the CPU runs without pause. Clearing the bit during a fetch window withdraws the request immediately. Setting it again takes effect at the start of the next display half.

The bus arbiter is a three-state machine. CPU_RUN means the CPU owns the bus. REQ_WAIT means a request is raised and the block waits for acknowledge. FETCH means the fetch window is open. The transitions are as follows. "start" goes from CPU_RUN to REQ_WAIT on a display-half start with the screen enabled. "grant" goes from REQ_WAIT to FETCH on an acknowledge. "finish" goes from REQ_WAIT or FETCH to CPU_RUN at the end of the display half. "cancel" goes from REQ_WAIT or FETCH to CPU_RUN when the screen bit is 0. Both "finish" and "cancel" take priority over "grant".

Top module: `vidshare_ctrl`

## Requirements
- R1: After reset, busreq is 0, fetch_win is 0, blank is 1 and the screen-enable bit is 0.
- R2: The timer counts HALF_CLKS clocks per half, starting in the CPU half at reset. With the screen enabled, busreq rises at the clock edge that ends clock HALF_CLKS after reset, and again every 2*HALF_CLKS clocks after that.
- R3: fetch_win rises only at the edge after a clock in which busreq was 1 and busack was sampled 1.
- R4: busreq and fetch_win fall at the edge that ends the display half, so busreq stays high for exactly HALF_CLKS clocks when the screen stays enabled.
- R5: A write to address 0xF0 latches data bit 2 as the screen-enable bit, with 1 meaning enabled. When the bit is 0, busreq falls at the next edge after the latch and no new request is raised.
- R6: Setting the screen-enable bit during a display half raises no request until the next display-half start.
- R7: Writes to any other address, and all data bits other than bit 2, do not affect the block.
- R8: blank is 1 exactly when fetch_win is 0, so the display stays blank while the screen is disabled.
- R9: If busack never arrives during a display half, fetch_win stays 0 and busreq still falls at the end of that half.
- R10: fetch_win is never 1 while busreq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock (2 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one clock per write |
| io_addr | input | 8 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| busack | input | 1 | Bus acknowledge from the CPU, active high |
| busreq | output | 1 | Bus request to the CPU, active high |
| fetch_win | output | 1 | Display may read video memory |
| blank | output | 1 | Display output forced blank |

## Verification
The bench builds the block with HALF_CLKS set to 20, so one frame lasts 40 clocks. This lets a run cover many frame boundaries, mid-half enables and disables, and acknowledge delays both shorter and longer than a whole display half. The acknowledge delay is varied from one clock up to more than a half-frame. This exercises a grant arriving on the first request clock as well as a grant that never arrives before the request is withdrawn.

// File: rtl/vidshare_pkg.sv
package vidshare_pkg;

    typedef enum logic [1:0] {
        ARB_CPU_RUN  = 2'd0,
        ARB_REQ_WAIT = 2'd1,
        ARB_FETCH    = 2'd2
    } arb_state_t;

endpackage

// File: rtl/vidshare_timer.sv
module vidshare_timer #(
    parameter int HALF_CLKS = 20492
) (
    input  logic clk,
    input  logic rst_n,
    output logic disp_start,
    output logic disp_end,
    output logic in_disp
);
    localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic             wrap;

    assign wrap       = (cnt_q == LAST);
    assign disp_start = wrap && !phase_q;
    assign disp_end   = wrap && phase_q;
    assign in_disp    = phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (wrap) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_phase_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/vidshare_portreg.sv
module vidshare_portreg #(
    parameter int               ADDR_W    = 8,
    parameter int               DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hF0,
    parameter int               EN_BIT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              scr_en
);
    logic hit;

    assign hit = io_wr && (io_addr == PORT_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scr_en <= 1'b0;
        end else if (hit) begin
            scr_en <= io_wdata[EN_BIT];
        end
    end

    p_other_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr != PORT_ADDR) |=> $stable(scr_en));

    p_latch_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == PORT_ADDR) |=> (scr_en == $past(io_wdata[EN_BIT])));

endmodule

// File: rtl/vidshare_arb.sv
module vidshare_arb
    import vidshare_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scr_en,
    input  logic busack,
    input  logic disp_start,
    input  logic disp_end,
    output logic busreq,
    output logic fetch_win,
    output logic blank
);
    arb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_CPU_RUN: begin
                if (scr_en && disp_start) state_d = ARB_REQ_WAIT;
            end
            ARB_REQ_WAIT: begin
                if (!scr_en || disp_end)  state_d = ARB_CPU_RUN;
                else if (busack)          state_d = ARB_FETCH;
            end
            ARB_FETCH: begin
                if (!scr_en || disp_end)  state_d = ARB_CPU_RUN;
            end
            default: state_d = ARB_CPU_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_CPU_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        busreq    = 1'b0;
        fetch_win = 1'b0;
        blank     = 1'b1;
        unique case (state_q)
            ARB_CPU_RUN: ;
            ARB_REQ_WAIT: busreq = 1'b1;
            ARB_FETCH: begin
                busreq    = 1'b1;
                fetch_win = 1'b1;
                blank     = 1'b0;
            end
            default: ;
        endcase
    end

    p_req_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busreq) |-> $past(disp_start));

    p_fetch_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_win) |-> ($past(busack) && $past(busreq)));

    p_req_drop_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_end |=> !busreq);

    p_off_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_en |=> !busreq);

    p_fetch_in_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_win |-> busreq);

endmodule

// File: rtl/vidshare_ctrl.sv
module vidshare_ctrl #(
    parameter int HALF_CLKS = 20492,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PORT_ADDR = 'hF0,
    parameter int EN_BIT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              busack,
    output logic              busreq,
    output logic              fetch_win,
    output logic              blank
);
    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT_ADDR);

    logic scr_en;
    logic disp_start;
    logic disp_end;
    logic in_disp;

    vidshare_portreg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PORT_ADDR(PORT_A),
        .EN_BIT   (EN_BIT)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .scr_en  (scr_en)
    );

    vidshare_timer #(
        .HALF_CLKS(HALF_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_start(disp_start),
        .disp_end  (disp_end),
        .in_disp   (in_disp)
    );

    vidshare_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .scr_en    (scr_en),
        .busack    (busack),
        .disp_start(disp_start),
        .disp_end  (disp_end),
        .busreq    (busreq),
        .fetch_win (fetch_win),
        .blank     (blank)
    );

    p_req_in_disp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busreq |-> in_disp);

    p_blank_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_en |=> blank);

endmodule

// File: tb/vidshare_ctrl_tb.sv
`timescale 1ns/1ps
module vidshare_ctrl_tb;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic       busack = 1'b0;
    logic       busreq, fetch_win, blank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    int  m_e   = 0;   // edges since reset
    int  m_st  = 0;   // 0 cpu, 1 waiting, 2 fetching
    bit  m_scr = 1'b0;
    int  lag   = 2;
    int  reqcnt = 0;

    always #10 clk = ~clk;

    vidshare_ctrl #(.HALF_CLKS(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .busack(busack), .busreq(busreq),
        .fetch_win(fetch_win), .blank(blank)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at edge %0d", req, act, exp, m_e);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            int ph;
            bit ds, de;
            ph = (m_e / H) % 2;
            ds = (ph == 0) && (m_e % H == H - 1);
            de = (ph == 1) && (m_e % H == H - 1);
            if (m_st == 0) begin
                if (m_scr && ds) m_st = 1;
            end else if (!m_scr || de) begin
                m_st = 0;
            end else if (m_st == 1 && busack) begin
                m_st = 2;
            end
            if (io_wr && io_addr == 8'hF0) m_scr = io_wdata[2];
            m_e++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R4 busreq", busreq, m_st != 0);
            chk("R3 R9 fetch_win", fetch_win, m_st == 2);
            chk("R8 blank", blank, m_st != 2);
            if (fetch_win) chk("R10 fetch implies req", busreq, 1'b1);
        end
        if (busreq) reqcnt++; else reqcnt = 0;
        busack <= busreq && (reqcnt > lag);
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic wait_pos(input int ph, input int pos);
        while (!(((m_e / H) % 2 == ph) && (m_e % H == pos))) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R1 busreq reset", busreq, 1'b0);
        chk("R1 fetch_win reset", fetch_win, 1'b0);
        chk("R1 blank reset", blank, 1'b1);
        rst_n = 1'b1;
        tick(2 * H + 5);
        chk("R1 screen off after reset", busreq, 1'b0);

        // enable, lag 2
        lag = 2;
        wait_pos(0, 2);
        wr(8'hF0, 8'h04);
        wait_pos(1, 0);
        @(negedge clk);
        chk("R2 request at half start", busreq, 1'b1);
        wait_pos(0, 0);
        @(negedge clk);
        chk("R4 request dropped at half end", busreq, 1'b0);
        tick(4 * H);

        // immediate grant
        lag = 0;
        tick(4 * H);

        // grant never arrives
        lag = 3 * H;
        wait_pos(1, H - 2);
        @(negedge clk);
        chk("R9 no fetch without ack", fetch_win, 1'b0);
        tick(3 * H);

        // disable during fetch window
        lag = 1;
        wait_pos(1, 8);
        chk("R3 fetch open before disable", fetch_win, 1'b1);
        wr(8'hF0, 8'h00);
        tick(1);
        chk("R5 request withdrawn", busreq, 1'b0);
        tick(3 * H);
        chk("R5 no request while off", busreq, 1'b0);

        // enable mid display half
        wait_pos(1, 3);
        wr(8'hF0, 8'h04);
        tick(5);
        chk("R6 no request until next half", busreq, 1'b0);
        tick(3 * H);

        // foreign address and other bits
        wait_pos(1, 6);
        wr(8'hF1, 8'h00);
        tick(2);
        chk("R7 other address ignored", busreq, 1'b1);
        wr(8'hF0, 8'hFB);
        tick(1);
        chk("R7 only bit 2 matters", busreq, 1'b0);
        wr(8'hF0, 8'h04);
        tick(4 * H);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule